// File: doc/BRIEF.md
# VLIW Bundle Issue Checker

This block sits at the issue stage of a five-slot VLIW pipeline. Each cycle it inspects one bundle of up to five operations. Each operation carries a valid bit, a unit class code, a destination register index and two source register indices. The block decides whether the bundle may issue, must be held back, or must be rejected.

A bundle is rejected when one of these holds:
- an operation sits in a slot its unit class may not use;
- an operation uses an undefined class code;
- a class is used by more operations than it has hardware copies.

A rejected bundle is never issued, and a one-cycle error flag follows it. A legal bundle is held (stall) in two cases:
- one of its valid operations reads a register whose result is still in flight;
- it carries a divide/square-root operation while the single, non-pipelined divider is still busy.

The upstream fetch logic keeps a stalled bundle steady until `issue` rises. It drops a rejected bundle.

A per-register countdown scoreboard tracks the result latency. Results come back after 1, 3 or 17 cycles, depending on the unit class.

Top module: `vliw_issue_check`

## Requirements
- R1: Class codes are: 0 constant, 1 integer ALU, 2 shifter, 3 load/store, 4 multiply, 5 FP ALU, 6 FP compare, 7 FP divide/sqrt, 8 branch, 9 DSP ALU, 10 DSP multiply. The class field of slot N is at bits [4N-1:4N-4] of `slot_cls`. The allowed slots per class are:
  - classes 0, 1 and 2: any slot;
  - class 6: slot 3 only;
  - classes 3, 4, 5 and 10: slots 4 and 5;
  - class 9: slots 1, 3 and 4;
  - class 8: slots 2, 3 and 4;
  - class 7: slot 2 only.
  A valid operation outside its allowed slots makes the bundle illegal.
- R2: A bundle is illegal when more valid operations use a class than it has copies. The copy counts are: classes 0 and 1 five each; class 8 three; classes 2, 3, 4, 5, 9 and 10 two each; classes 6 and 7 one each.
- R3: Class codes 11 to 15 in a valid slot make the bundle illegal. Invalid slots are ignored whatever their contents.
- R4: An illegal bundle with `in_valid` high does not issue. It raises `illegal` for exactly the following cycle, and it leaves the scoreboard unchanged.
- R5: A dependent operation can issue 1 cycle after a producer of class 0, 1, 2 or 6. It can issue 3 cycles after a producer of class 3, 4, 5, 8, 9 or 10, and 17 cycles after a producer of class 7. This means 0, 2 and 16 stall cycles respectively.
- R6: A legal bundle stalls while any source of a valid slot has a pending result. Sources of invalid slots never cause a stall.
- R7: A divide/sqrt issue sets `div_busy` for 16 cycles. A legal bundle with a divide/sqrt operation stalls while `div_busy` is high.
- R8: Pipelined classes accept new operations every cycle. Three consecutive bundles with two load/store operations each issue on three consecutive cycles.
- R9: When several issued slots name the same destination, the latency of the highest-numbered slot takes effect.
- R10: Reset clears all register countdowns, the divider busy state and `illegal`.
- R11: `issue` equals `in_valid` and legal and not stalled. `stall` is high only for a legal valid bundle that has a hazard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A bundle is presented this cycle |
| slot_v | input | 5 | Per-slot operation valid, bit 0 = slot 1 |
| slot_cls | input | 20 | Per-slot 4-bit unit class code |
| slot_dst | input | 35 | Per-slot 7-bit destination register |
| slot_srca | input | 35 | Per-slot 7-bit first source register |
| slot_srcb | input | 35 | Per-slot 7-bit second source register |
| issue | output | 1 | Bundle accepted this cycle |
| stall | output | 1 | Legal bundle held for a hazard |
| illegal | output | 1 | Previous-cycle bundle was rejected |
| div_busy | output | 1 | Divide/sqrt unit occupied |

## Verification
The bench keeps the default parameters: 128 registers, a middle latency of 3 and a divider latency of 17. With these values the full 16-cycle divider window and the 2-cycle load shadow are counted cycle by cycle, and the real copy counts let the copy-overflow cases be reached. A vector table covers slot legality and copy counts for every class group. Directed cases then exercise the latency classes, divider occupancy, same-destination priority, ignored invalid slots, and reset during a busy divider.

// File: rtl/vliw_chk_pkg.sv
// Shared definitions for the bundle issue checker: slot count, unit class
// codes, and the per-class slot masks, copy counts and latency groups.
// Assumes slot index 0 corresponds to bundle slot 1.
package vliw_chk_pkg;
    localparam int NSLOT = 5;
    localparam int CLSW  = 4;

    typedef enum logic [CLSW-1:0] {
        CL_CONST  = 4'd0,
        CL_IALU   = 4'd1,
        CL_SHIFT  = 4'd2,
        CL_LDST   = 4'd3,
        CL_MUL    = 4'd4,
        CL_FALU   = 4'd5,
        CL_FCMP   = 4'd6,
        CL_FDIV   = 4'd7,
        CL_BRANCH = 4'd8,
        CL_DALU   = 4'd9,
        CL_DMUL   = 4'd10
    } unit_cls_e;

    typedef enum logic [1:0] {LAT_ONE, LAT_MID, LAT_DIV, LAT_NONE} lat_grp_e;

    // Slots a class may occupy; bit 0 is slot 1. Undefined codes get none.
    function automatic logic [NSLOT-1:0] slot_mask(input logic [CLSW-1:0] c);
        case (c)
            CL_CONST, CL_IALU, CL_SHIFT:     return 5'b11111;
            CL_FCMP:                         return 5'b00100;
            CL_LDST, CL_MUL, CL_FALU, CL_DMUL: return 5'b11000;
            CL_DALU:                         return 5'b01101;
            CL_BRANCH:                       return 5'b01110;
            CL_FDIV:                         return 5'b00010;
            default:                         return 5'b00000;
        endcase
    endfunction

    // Number of hardware copies of each class.
    function automatic int copies(input logic [CLSW-1:0] c);
        case (c)
            CL_CONST, CL_IALU:  return 5;
            CL_BRANCH:          return 3;
            CL_SHIFT, CL_LDST, CL_MUL, CL_FALU, CL_DALU, CL_DMUL: return 2;
            CL_FCMP, CL_FDIV:   return 1;
            default:            return 0;
        endcase
    endfunction

    // Latency group of each class.
    function automatic lat_grp_e lat_grp(input logic [CLSW-1:0] c);
        case (c)
            CL_CONST, CL_IALU, CL_SHIFT, CL_FCMP: return LAT_ONE;
            CL_FDIV:                              return LAT_DIV;
            CL_LDST, CL_MUL, CL_FALU, CL_BRANCH, CL_DALU, CL_DMUL: return LAT_MID;
            default:                              return LAT_NONE;
        endcase
    endfunction
endpackage

// File: rtl/vliw_rule_check.sv
// Combinational bundle legality: slot placement per class and copy counts.
// Assumes invalid slots carry arbitrary content and must be ignored.
module vliw_rule_check
    import vliw_chk_pkg::*;
(
    input  logic [NSLOT-1:0]      slot_v,
    input  logic [NSLOT*CLSW-1:0] slot_cls,
    output logic                  bad
);
    localparam int NCODE = 1 << CLSW;

    logic [NSLOT-1:0] place_bad;
    logic             over;

    // Per-slot placement check against the class slot mask.
    for (genvar s = 0; s < NSLOT; s++) begin : g_place
        logic [NSLOT-1:0] m;
        assign m            = slot_mask(slot_cls[s*CLSW +: CLSW]);
        assign place_bad[s] = slot_v[s] & ~m[s];
    end

    // Copy-count check: tally valid operations for every class code.
    always_comb begin
        over = 1'b0;
        for (int k = 0; k < NCODE; k++) begin
            int cnt;
            cnt = 0;
            for (int s = 0; s < NSLOT; s++)
                if (slot_v[s] && slot_cls[s*CLSW +: CLSW] == CLSW'(k))
                    cnt++;
            if (cnt > copies(CLSW'(k)))
                over = 1'b1;
        end
    end

    assign bad = (|place_bad) | over;
endmodule

// File: rtl/vliw_div_track.sv
// Occupancy tracker for the single non-pipelined divide/sqrt unit.
// Assumes DIV_LAT >= 2; busy lasts DIV_LAT-1 cycles after the issue edge.
module vliw_div_track #(
    parameter int DIV_LAT = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(DIV_LAT);

    logic [CW-1:0] remain;

    // Load the run length on start, then count down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)            remain <= '0;
        else if (start)        remain <= CW'(DIV_LAT - 1);
        else if (remain != '0) remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/vliw_scoreboard.sv
// Per-register result countdown. A register is ready when its count is zero.
// On issue, each valid slot loads its wait (latency minus one) into its
// destination; the highest slot wins. Assumes NREG is a power of two.
module vliw_scoreboard
    import vliw_chk_pkg::*;
#(
    parameter int NREG = 128,
    parameter int CW   = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           issue,
    input  logic [NSLOT-1:0]               slot_v,
    input  logic [NSLOT*$clog2(NREG)-1:0]  slot_dst,
    input  logic [NSLOT*$clog2(NREG)-1:0]  slot_srca,
    input  logic [NSLOT*$clog2(NREG)-1:0]  slot_srcb,
    input  logic [NSLOT*CW-1:0]            slot_wait,
    output logic                           hazard
);
    localparam int RW = $clog2(NREG);

    logic [NREG-1:0][CW-1:0] pend, pend_nxt;

    // Source hazard: any valid slot reading a register still counting.
    always_comb begin
        hazard = 1'b0;
        for (int s = 0; s < NSLOT; s++)
            if (slot_v[s] && (pend[slot_srca[s*RW +: RW]] != '0 ||
                              pend[slot_srcb[s*RW +: RW]] != '0))
                hazard = 1'b1;
    end

    // Next counts: decrement, then overwrite by issuing slots in slot order.
    always_comb begin
        for (int r = 0; r < NREG; r++) begin
            pend_nxt[r] = (pend[r] != '0) ? pend[r] - 1'b1 : '0;
            if (issue)
                for (int s = 0; s < NSLOT; s++)
                    if (slot_v[s] && slot_dst[s*RW +: RW] == RW'(r))
                        pend_nxt[r] = slot_wait[s*CW +: CW];
        end
    end

    // Count register update.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= pend_nxt;
    end
endmodule

// File: rtl/vliw_issue_check.sv
// Issue-stage checker for a five-slot VLIW bundle. Rejects illegal bundles
// with a one-cycle flag, stalls on operand or divider hazards, otherwise
// issues. Assumes upstream holds a stalled bundle steady until issue.
module vliw_issue_check
    import vliw_chk_pkg::*;
#(
    parameter int NREG    = 128,
    parameter int MID_LAT = 3,
    parameter int DIV_LAT = 17
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [NSLOT-1:0]              slot_v,
    input  logic [NSLOT*CLSW-1:0]         slot_cls,
    input  logic [NSLOT*$clog2(NREG)-1:0] slot_dst,
    input  logic [NSLOT*$clog2(NREG)-1:0] slot_srca,
    input  logic [NSLOT*$clog2(NREG)-1:0] slot_srcb,
    output logic                          issue,
    output logic                          stall,
    output logic                          illegal
    ,output logic                         div_busy
);
    localparam int CW = $clog2(DIV_LAT);

    logic              bad, src_hazard, div_req, illegal_q;
    logic [NSLOT*CW-1:0] slot_wait;

    vliw_rule_check u_rules (
        .slot_v   (slot_v),
        .slot_cls (slot_cls),
        .bad      (bad)
    );

    // Per-slot wait value and divide/sqrt request from the class codes.
    always_comb begin
        div_req = 1'b0;
        for (int s = 0; s < NSLOT; s++) begin
            case (lat_grp(slot_cls[s*CLSW +: CLSW]))
                LAT_DIV: slot_wait[s*CW +: CW] = CW'(DIV_LAT - 1);
                LAT_MID: slot_wait[s*CW +: CW] = CW'(MID_LAT - 1);
                default: slot_wait[s*CW +: CW] = '0;
            endcase
            if (slot_v[s] && slot_cls[s*CLSW +: CLSW] == CL_FDIV)
                div_req = 1'b1;
        end
    end

    vliw_scoreboard #(.NREG(NREG), .CW(CW)) u_sb (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (issue),
        .slot_v    (slot_v),
        .slot_dst  (slot_dst),
        .slot_srca (slot_srca),
        .slot_srcb (slot_srcb),
        .slot_wait (slot_wait),
        .hazard    (src_hazard)
    );

    vliw_div_track #(.DIV_LAT(DIV_LAT)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (issue & div_req),
        .busy  (div_busy)
    );

    assign stall = in_valid & ~bad & (src_hazard | (div_req & div_busy));
    assign issue = in_valid & ~bad & ~src_hazard & ~(div_req & div_busy);

    // One-cycle error flag for a rejected bundle.
    always_ff @(posedge clk) begin
        if (!rst_n) illegal_q <= 1'b0;
        else        illegal_q <= in_valid & bad;
    end

    assign illegal = illegal_q;
endmodule

// File: rtl/vliw_issue_check_sva.sv
// Property checker for vliw_issue_check, attached by bind. Observes ports only.
module vliw_issue_check_sva
    import vliw_chk_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [NSLOT-1:0]      slot_v,
    input logic [NSLOT*CLSW-1:0] slot_cls,
    input logic                  issue,
    input logic                  stall,
    input logic                  illegal,
    input logic                  div_busy
);
    logic fdiv_in;

    // Bundle carries a valid divide/sqrt operation.
    always_comb begin
        fdiv_in = 1'b0;
        for (int s = 0; s < NSLOT; s++)
            if (slot_v[s] && slot_cls[s*CLSW +: CLSW] == CL_FDIV) fdiv_in = 1'b1;
    end

    assert_issue_stall_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue && stall));
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!issue && !stall));
    assert_illegal_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> ($past(in_valid) && !$past(issue)));
    assert_issue_no_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !illegal);
    assert_div_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_busy) |-> $past(issue));
    assert_div_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (div_busy && fdiv_in) |-> !issue);
endmodule

bind vliw_issue_check vliw_issue_check_sva u_sva (.*);

// File: tb/vliw_issue_check_bench.sv
module vliw_issue_check_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;

    typedef struct packed {
        logic [4:0]      v;
        logic [4:0][3:0] c;
        logic            bad;
    } vec_t;

    // Legality vectors: class nibbles listed slot5..slot1.
    localparam vec_t TAB [NV] = '{
        '{5'b11111, 20'h11111, 1'b0},  // R1 R2 five integer ALU
        '{5'b11111, 20'h00000, 1'b0},  // R1 R2 five constants
        '{5'b00011, 20'h00022, 1'b0},  // R2 two shifters
        '{5'b00111, 20'h00222, 1'b1},  // R2 three shifters
        '{5'b00100, 20'h00600, 1'b0},  // R1 FP compare slot 3
        '{5'b00001, 20'h00006, 1'b1},  // R1 FP compare slot 1
        '{5'b11000, 20'h33000, 1'b0},  // R1 loads slots 4,5
        '{5'b00100, 20'h00300, 1'b1},  // R1 load slot 3
        '{5'b00001, 20'h00007, 1'b1},  // R1 divide slot 1
        '{5'b01101, 20'h09909, 1'b1},  // R2 three DSP ALU
        '{5'b00101, 20'h00909, 1'b0},  // R1 DSP ALU slots 1,3
        '{5'b01110, 20'h08880, 1'b0},  // R1 R2 branches 2,3,4
        '{5'b10000, 20'h80000, 1'b1},  // R1 branch slot 5
        '{5'b00001, 20'h0000C, 1'b1},  // R3 undefined code
        '{5'b00001, 20'hF0001, 1'b0},  // R3 invalid slot ignored
        '{5'b11000, 20'h4A000, 1'b0},  // R1 multiply and DSP multiply
        '{5'b00010, 20'h00040, 1'b1},  // R1 multiply slot 2
        '{5'b00010, 20'h00070, 1'b0}   // R1 divide slot 2
    };

    localparam logic [3:0] C_CONST = 4'd0, C_IALU = 4'd1, C_SHIFT = 4'd2,
                           C_LDST = 4'd3, C_MUL = 4'd4, C_FCMP = 4'd6,
                           C_FDIV = 4'd7;

    logic clk = 1'b0, rst_n = 1'b0, in_valid;
    logic [4:0]      sv;
    logic [4:0][3:0] sc;
    logic [4:0][6:0] sd, sa, sb;
    logic issue, stall, illegal, div_busy;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vliw_issue_check u_vliw_issue_check (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .slot_v(sv),
        .slot_cls(sc), .slot_dst(sd), .slot_srca(sa), .slot_srcb(sb),
        .issue(issue), .stall(stall), .illegal(illegal), .div_busy(div_busy)
    );

    task automatic clr();
        in_valid = 1'b0; sv = '0; sc = '0; sd = '0; sa = '0; sb = '0;
    endtask

    task automatic put(input int slot, input logic [3:0] c, input logic [6:0] d,
                       input logic [6:0] a, input logic [6:0] b);
        sv[slot-1] = 1'b1; sc[slot-1] = c; sd[slot-1] = d;
        sa[slot-1] = a;    sb[slot-1] = b; in_valid = 1'b1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count stall cycles until the held bundle issues; returns after that edge.
    task automatic wait_issue(output int n);
        n = 0;
        #1;
        while (!issue && n < 40) begin
            n++;
            @(negedge clk); #1;
        end
        @(negedge clk);
    endtask

    initial begin
        int n;
        clr();
        repeat (3) @(negedge clk);
        #1;
        chk("R10 reset div_busy", int'(div_busy), 0);
        chk("R10 reset illegal", int'(illegal), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R11 idle issue", int'(issue), 0);
        chk("R11 idle stall", int'(stall), 0);

        // Legality table
        for (int i = 0; i < NV; i++) begin
            clr();
            sv = TAB[i].v; sc = TAB[i].c; in_valid = 1'b1;
            for (int s = 0; s < 5; s++) sd[s] = 7'(100 + s);
            #1;
            chk($sformatf("R1/R2/R3 vec %0d issue", i), int'(issue), int'(!TAB[i].bad));
            chk($sformatf("R11 vec %0d stall", i), int'(stall), 0);
            @(negedge clk); #1;
            chk($sformatf("R4 vec %0d illegal", i), int'(illegal), int'(TAB[i].bad));
        end
        clr();
        repeat (20) @(negedge clk);

        // R5 load latency: two stall cycles
        clr(); put(4, C_LDST, 7'd5, 0, 0); wait_issue(n);
        chk("R5 load issue", n, 0);
        clr(); put(1, C_IALU, 7'd30, 7'd5, 0); #1;
        chk("R6 stall on pending source", int'(stall), 1);
        wait_issue(n);
        chk("R5 load latency stalls", n, 2);
        // R5 one-cycle classes
        clr(); put(1, C_SHIFT, 7'd6, 0, 0); wait_issue(n);
        clr(); put(2, C_IALU, 7'd31, 0, 7'd6); wait_issue(n);
        chk("R5 shifter latency stalls", n, 0);
        clr(); put(3, C_FCMP, 7'd7, 0, 0); wait_issue(n);
        clr(); put(5, C_CONST, 7'd36, 7'd7, 0); wait_issue(n);
        chk("R5 compare latency stalls", n, 0);
        // R5 divide latency
        clr(); put(2, C_FDIV, 7'd8, 0, 0); wait_issue(n);
        clr(); put(1, C_IALU, 7'd32, 0, 7'd8); wait_issue(n);
        chk("R5 divide latency stalls", n, 16);
        // R7 divider occupancy
        clr(); put(2, C_FDIV, 7'd9, 0, 0); wait_issue(n);
        #1 chk("R7 div_busy after issue", int'(div_busy), 1);
        clr(); put(2, C_FDIV, 7'd10, 0, 0); wait_issue(n);
        chk("R7 second divide stalls", n, 16);
        // R8 back-to-back loads
        for (int i = 0; i < 3; i++) begin
            clr();
            put(4, C_LDST, 7'(40 + 2*i), 0, 0);
            put(5, C_LDST, 7'(41 + 2*i), 0, 0);
            #1 chk($sformatf("R8 load pair %0d issue", i), int'(issue), 1);
            @(negedge clk);
        end
        // R9 same destination, highest slot wins
        clr(); put(1, C_IALU, 7'd11, 0, 0); put(4, C_LDST, 7'd11, 0, 0); wait_issue(n);
        clr(); put(1, C_IALU, 7'd37, 7'd11, 0); wait_issue(n);
        chk("R9 slot 4 latency wins", n, 2);
        clr(); put(4, C_MUL, 7'd12, 0, 0); put(5, C_IALU, 7'd12, 0, 0); wait_issue(n);
        clr(); put(1, C_IALU, 7'd38, 7'd12, 0); wait_issue(n);
        chk("R9 slot 5 latency wins", n, 0);
        // R6 invalid slot source ignored
        clr(); put(4, C_LDST, 7'd13, 0, 0); wait_issue(n);
        clr(); put(1, C_IALU, 7'd39, 0, 0); sa[1] = 7'd13; sb[1] = 7'd13;
        #1 chk("R6 invalid slot source ignored", int'(issue), 1);
        @(negedge clk);
        // R4 illegal bundle leaves scoreboard untouched
        clr(); put(1, C_LDST, 7'd14, 0, 0); #1;
        chk("R4 illegal not issued", int'(issue), 0);
        @(negedge clk); #1;
        chk("R4 illegal flag", int'(illegal), 1);
        clr(); put(1, C_IALU, 7'd50, 7'd14, 0); #1;
        chk("R4 no scoreboard write", int'(issue), 1);
        @(negedge clk); #1;
        chk("R4 flag lasts one cycle", int'(illegal), 0);
        // R11 illegal bundle with pending source does not stall
        clr(); put(4, C_LDST, 7'd15, 0, 0); wait_issue(n);
        clr(); put(1, C_LDST, 7'd51, 7'd15, 0); #1;
        chk("R11 illegal never stalls", int'(stall), 0);
        @(negedge clk);
        // R10 reset during busy divider
        clr(); put(2, C_FDIV, 7'd20, 0, 0); wait_issue(n);
        clr(); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        chk("R10 div_busy cleared", int'(div_busy), 0);
        put(2, C_FDIV, 7'd21, 7'd20, 0); #1;
        chk("R10 counts cleared", int'(issue), 1);
        @(negedge clk); clr();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule